// File: doc/BRIEF.md
# Frame-Size-Scaled Transmit/Receive FIFO Pair

This block buffers the data words of a serial peripheral in two queues: a transmit queue filled by register writes and drained by the shift engine, and a receive queue filled by the shift engine and drained by register reads. Each entry holds up to 32 bits. Both queues share one effective depth. A large-queue switch and a 5-bit frame-size field select that depth, so narrow frames get more entries.

The block drives a 16-bit status word with full, one-from-full and empty flags for each queue, plus a sticky receive-overflow bit. It also drives a separate raw overflow interrupt flag. When the receive queue is at depth and a word arrives, the word is dropped and overflow is flagged. When the effective depth changes, both queues are flushed, so occupancy never exceeds the new depth.

Top module: `sized_fifo_pair`

## Requirements
- R1: After reset both queues are empty, `status` reads 0x0440 (receive empty at bit 6, transmit empty at bit 10, every other bit 0), `frame_size` is 4, `ovf_raw` is 0 and `rx_rdata` is 0.
- R2: With `big_mode` low the effective depth is 4 entries, whatever the frame size.
- R3: With `big_mode` high the effective depth is 32 for frame sizes 0 to 8, 16 for sizes 9 to 16, and 8 for sizes 17 to 31.
- R4: A frame-size write (`fsz_wr`) takes effect only while `enable` is low; while `enable` is high the write is ignored and `frame_size` keeps its value.
- R5: For each queue, the full flag (receive bit 4, transmit bit 8) is set when occupancy equals the depth. The one-from-full flag (bits 5, 9) is set when occupancy equals depth minus one. The empty flag (bits 6, 10) is set when occupancy is zero.
- R6: A transmit push made while the transmit queue holds depth entries, without a pop in the same cycle, is discarded and changes nothing.
- R7: A receive push made while the receive queue holds depth entries, without a pop in the same cycle, drops the word and sets both status bit 2 (sticky overflow) and `ovf_raw`.
- R8: A receive pop returns the oldest entry and clears status bit 2. `ovf_raw` stays set until `ovf_clr` is pulsed.
- R9: A receive pop on an empty receive queue returns zero and leaves the queue empty.
- R10: Any change of effective depth, whether from `big_mode` or from an accepted frame-size write, empties both queues in the same cycle.
- R11: Both queues are first-in first-out: `tx_rdata` and `rx_rdata` present the oldest stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enabled; locks the frame size |
| big_mode | input | 1 | Large-queue depth selection |
| fsz_wr | input | 1 | Frame-size write strobe |
| fsz_wdata | input | 5 | Frame-size write value |
| tx_push | input | 1 | Register write into transmit queue |
| tx_wdata | input | 32 | Transmit word |
| tx_pop | input | 1 | Shift engine takes transmit head |
| tx_rdata | output | 32 | Transmit head word |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_wdata | input | 32 | Received word |
| rx_pop | input | 1 | Register read of receive data |
| rx_rdata | output | 32 | Receive head word, zero when empty |
| ovf_clr | input | 1 | Clears the raw overflow flag |
| status | output | 16 | Flag word (bits 2, 4, 5, 6, 8, 9, 10) |
| frame_size | output | 5 | Current frame size |
| ovf_raw | output | 1 | Raw overflow interrupt flag |

## Verification
The queues are first filled past depth in small mode, which separates the 4-entry limit from the drop and overflow behaviour. Large mode is then tried at three frame sizes, each filling to exactly the expected depth, so that a wrong size range shows up as a flag raised too early or too late. Depth switches are made with data still queued, to tell a flush apart from a mere flag recomputation. Data ordering is checked by a scoreboard of queued words compared on every pop, including a pop from an empty queue, which must return zero.

// File: rtl/sized_fifo_pair.sv
module sized_fifo_pair #(
  parameter int W = 32,
  parameter int MAXD = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         big_mode,
  input  logic         fsz_wr,
  input  logic [4:0]   fsz_wdata,
  input  logic         tx_push,
  input  logic [W-1:0] tx_wdata,
  input  logic         tx_pop,
  output logic [W-1:0] tx_rdata,
  input  logic         rx_push,
  input  logic [W-1:0] rx_wdata,
  input  logic         rx_pop,
  output logic [W-1:0] rx_rdata,
  input  logic         ovf_clr,
  output logic [15:0]  status,
  output logic [4:0]   frame_size,
  output logic         ovf_raw
);
  localparam int AW = $clog2(MAXD);
  localparam int CW = AW + 1;

  function automatic logic [CW-1:0] depth_of(input logic big, input logic [4:0] fs);
    if (!big) return CW'(4);
    if (fs <= 5'd8) return CW'(MAXD);
    if (fs <= 5'd16) return CW'(MAXD / 2);
    return CW'(MAXD / 4);
  endfunction

  logic [W-1:0]  tx_mem [MAXD];
  logic [W-1:0]  rx_mem [MAXD];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          big_q, ovf_st;

  logic [4:0]    fsz_nx;
  logic [CW-1:0] depth, depth_nx;
  logic          flush, tx_give, tx_take, rx_give, rx_take;

  assign fsz_nx   = (fsz_wr && !enable) ? fsz_wdata : frame_size;
  assign depth    = depth_of(big_q, frame_size);
  assign depth_nx = depth_of(big_mode, fsz_nx);
  assign flush    = depth_nx != depth;

  assign tx_give = tx_pop && tx_cnt != 0;
  assign tx_take = tx_push && (tx_cnt < depth || tx_give);
  assign rx_give = rx_pop && rx_cnt != 0;
  assign rx_take = rx_push && (rx_cnt < depth || rx_give);

  assign tx_rdata = (tx_cnt != 0) ? tx_mem[tx_rp] : '0;
  assign rx_rdata = (rx_cnt != 0) ? rx_mem[rx_rp] : '0;

  always_comb begin
    status     = '0;
    status[2]  = ovf_st;
    status[4]  = rx_cnt == depth;
    status[5]  = rx_cnt == depth - 1'b1;
    status[6]  = rx_cnt == 0;
    status[8]  = tx_cnt == depth;
    status[9]  = tx_cnt == depth - 1'b1;
    status[10] = tx_cnt == 0;
  end

  always_ff @(posedge clk) begin
    if (tx_take && !flush) tx_mem[tx_wp] <= tx_wdata;
    if (rx_take && !flush) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_size <= 5'd4;
      big_q      <= 1'b0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      ovf_st  <= 1'b0;
      ovf_raw <= 1'b0;
    end else begin
      frame_size <= fsz_nx;
      big_q      <= big_mode;
      if (flush) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (tx_take) tx_wp <= tx_wp + 1'b1;
        if (tx_give) tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_take) - CW'(tx_give);
        if (rx_take) rx_wp <= rx_wp + 1'b1;
        if (rx_give) rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(rx_take) - CW'(rx_give);
      end
      if (rx_push && !rx_take && !flush) ovf_st <= 1'b1;
      else if (rx_pop) ovf_st <= 1'b0;
      if (rx_push && !rx_take && !flush) ovf_raw <= 1'b1;
      else if (ovf_clr) ovf_raw <= 1'b0;
    end
  end
endmodule

module sized_fifo_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        fsz_wr,
  input logic        tx_push,
  input logic        tx_pop,
  input logic        rx_push,
  input logic        rx_pop,
  input logic        flush,
  input logic [15:0] status,
  input logic [4:0]  frame_size,
  input logic        ovf_raw
);
  // R5
  rx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[4] && status[6]));
  // R5
  tx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[8] && status[10]));
  // R4
  fsz_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsz_wr && enable) |=> $stable(frame_size));
  // R6
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[8] && tx_push && !tx_pop && !flush) |=> status[8]);
  // R7
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && rx_push && !rx_pop && !flush) |=> (status[2] && ovf_raw));
  // R8
  ovf_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !status[2]);
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (status[6] && status[10]));
endmodule

bind sized_fifo_pair sized_fifo_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .fsz_wr(fsz_wr),
  .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
  .flush(flush), .status(status), .frame_size(frame_size), .ovf_raw(ovf_raw)
);

// File: tb/test_sized_fifo_pair.sv
module test_sized_fifo_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, big_mode = 0, fsz_wr = 0;
  logic [4:0] fsz_wdata = '0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, ovf_clr = 0;
  logic [31:0] tx_wdata = '0, rx_wdata = '0;
  logic [31:0] tx_rdata, rx_rdata;
  logic [15:0] status;
  logic [4:0]  frame_size;
  logic        ovf_raw;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [31:0] tx_q[$], rx_q[$];

  always #10 clk = ~clk;

  sized_fifo_pair i_sized_fifo_pair (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; fsz_wr = 0; ovf_clr = 0;
  endtask

  function automatic logic [15:0] flags(input int tc, input int rc, input int d, input logic ov);
    logic [15:0] s = '0;
    s[2] = ov;
    s[4] = rc == d; s[5] = rc == d - 1; s[6] = rc == 0;
    s[8] = tc == d; s[9] = tc == d - 1; s[10] = tc == 0;
    return s;
  endfunction

  task automatic push_tx(input logic [31:0] v, input int d);
    if (tx_q.size() < d) tx_q.push_back(v);
    tx_push = 1; tx_wdata = v; tick();
  endtask

  task automatic push_rx(input logic [31:0] v, input int d);
    if (rx_q.size() < d) rx_q.push_back(v);
    rx_push = 1; rx_wdata = v; tick();
  endtask

  task automatic pop_tx(input string req);
    logic [31:0] e;
    e = (tx_q.size() != 0) ? tx_q.pop_front() : 32'h0;
    chk(req, tx_rdata, e);
    tx_pop = 1; tick();
  endtask

  task automatic pop_rx(input string req);
    logic [31:0] e;
    e = (rx_q.size() != 0) ? rx_q.pop_front() : 32'h0;
    chk(req, rx_rdata, e);
    rx_pop = 1; tick();
  endtask

  task automatic set_fsz(input logic [4:0] v);
    fsz_wr = 1; fsz_wdata = v; tick();
  endtask

  initial begin
    #35 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 status", status, 32'h0440);
    chk("R1 frame_size", frame_size, 4);
    chk("R1 ovf_raw", ovf_raw, 0);
    chk("R1 rx_rdata", rx_rdata, 0);

    // R2 R5 R6 small mode: depth 4, fifth transmit word discarded
    for (int i = 0; i < 3; i++) push_tx(32'hA000_0000 + i, 4);
    chk("R5 tx almost", status, flags(3, 0, 4, 0));
    push_tx(32'hA000_0003, 4);
    chk("R2 tx full at 4", status, flags(4, 0, 4, 0));
    push_tx(32'hDEAD_BEEF, 4);
    chk("R6 tx push at depth", status, flags(4, 0, 4, 0));
    for (int i = 0; i < 4; i++) pop_tx("R11 R6 tx order");
    chk("R5 tx empty", status, flags(0, 0, 4, 0));

    // R7 R8 receive overflow
    for (int i = 0; i < 4; i++) push_rx(32'hB000_0000 + i, 4);
    chk("R5 rx full", status, flags(0, 4, 4, 0));
    push_rx(32'hBAD0_BAD0, 4);
    chk("R7 overflow status", status, flags(0, 4, 4, 1));
    chk("R7 overflow raw", ovf_raw, 1);
    pop_rx("R8 rx order");
    chk("R8 overflow cleared by read", status, flags(0, 3, 4, 0));
    chk("R8 raw kept", ovf_raw, 1);
    ovf_clr = 1; tick();
    chk("R8 raw cleared", ovf_raw, 0);
    for (int i = 0; i < 3; i++) pop_rx("R11 R7 rx order");
    // R9 pop on empty
    pop_rx("R9 empty pop data");
    chk("R9 still empty", status, flags(0, 0, 4, 0));

    // R4 frame-size write locked while enabled
    enable = 1; set_fsz(5'd20);
    chk("R4 ignored while enabled", frame_size, 4);
    enable = 0; set_fsz(5'd2);
    chk("R4 accepted while disabled", frame_size, 2);

    // R10 R3 big mode on with queued data: flush, depth 32
    push_tx(32'h1111_0000, 4); push_rx(32'h2222_0000, 4);
    big_mode = 1; tick();
    tx_q.delete(); rx_q.delete();
    chk("R10 flush on big_mode", status, flags(0, 0, 32, 0));
    for (int i = 0; i < 31; i++) push_rx(32'hC000_0000 + i, 32);
    chk("R3 depth 32 almost", status, flags(0, 31, 32, 0));
    push_rx(32'hC000_001F, 32);
    chk("R3 depth 32 full", status, flags(0, 32, 32, 0));
    pop_rx("R11 big rx order");
    pop_rx("R11 big rx order");

    // R3 R10 size 12 -> depth 16
    set_fsz(5'd12);
    rx_q.delete();
    chk("R10 flush on size", status, flags(0, 0, 16, 0));
    for (int i = 0; i < 16; i++) push_tx(32'hD000_0000 + i, 16);
    chk("R3 depth 16 full", status, flags(16, 0, 16, 0));
    pop_tx("R11 tx order depth 16");

    // R3 size 20 -> depth 8
    set_fsz(5'd20);
    tx_q.delete();
    for (int i = 0; i < 7; i++) push_tx(32'hE000_0000 + i, 8);
    chk("R3 depth 8 almost", status, flags(7, 0, 8, 0));
    push_tx(32'hE000_0007, 8);
    push_tx(32'hE000_0008, 8);
    chk("R3 R6 depth 8 full", status, flags(8, 0, 8, 0));
    for (int i = 0; i < 8; i++) pop_tx("R11 tx order depth 8");
    chk("R5 drained", status, flags(0, 0, 8, 0));

    // R2 back to small mode: size ignored
    big_mode = 0; tick();
    for (int i = 0; i < 4; i++) push_rx(32'hF000_0000 + i, 4);
    chk("R2 small depth again", status, flags(0, 4, 4, 0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule